// File: doc/BRIEF.md
# First-Fault Gather Load Sequencer

This block carries out a vector gather load of 64-bit words with first-fault semantics. It handles one element per memory transaction. A start pulse captures four things: a 64-bit base, an index vector, a predicate mask and the incoming first-fault register. For each active element the block forms an address from the base and that element's index, then issues a request on a single-outstanding valid/ready memory port. The response returns the data word and a fault flag.

The first active element goes out as a normal access. A fault on it is architectural: the block aborts and leaves its vector outputs untouched. Every later active element goes out as a non-faulting access. The first failure among these stops all further requests and clears the first-fault bits from that element to the end of the vector. The block then commits the result vector and the updated first-fault register, and pulses done.

The base comes from the general register value unless the register number is 31. In that case the stack pointer is used, and it must be 16-byte aligned.

Top module: `ffGatherSeq`

## Requirements
- R1: The address of element e is base + X, where X is the extended index of element e. With `scaleEn`=1, X is shifted left by 3 before the add. Requests are issued in ascending element order.
- R2: When `idx32Mode`=1, only bits [31:0] of each 64-bit index element are used. `signExt`=0 zero-extends them to 64 bits and `signExt`=1 sign-extends them.
- R3: When `idx32Mode`=0, the full 64-bit index element is used unchanged. `signExt` has no effect in this mode.
- R4: An element whose `predMask` bit is 0 issues no request. Its 64-bit slice of `resultVec` is zero.
- R5: The first active element is requested with `memReqNonFault`=0. Every later request of the same operation has `memReqNonFault`=1.
- R6: If the response to the first active element reports a fault, the block issues no further requests. It asserts `abortOut` together with `done`, and `resultVec` and `ffrOut` keep their previous values.
- R7: After a committed operation, `ffrOut[e]` equals `ffrIn[e]` for every element before the first faulting non-faulting access. It is 0 for that element and every later one, active or not. No request is issued after that fault.
- R8: The result slice of an active element that was accessed without fault is the returned 64-bit word, unmodified. This holds even when its `ffrIn` bit was already 0. The slice is zero for the faulting element and for every element after it.
- R9: If `baseRegNum`=31, the base is `stackPtr`. If bits [3:0] of `stackPtr` are then non-zero, the block aborts with no request. For any other `baseRegNum`, the base is `gprBase`.
- R10: A request stays asserted with a stable address and type until `memReqReady`. At most one request is outstanding at a time.
- R11: `done` is a one-cycle pulse after the last element. `resultVec` and `ffrOut` change only in the cycle after `done`.
- R12: After reset, `done`, `abortOut` and `memReqValid` are 0, and `resultVec` and `ffrOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| baseRegNum | input | 5 | Base register number; 31 selects the stack pointer |
| gprBase | input | 64 | General register base value |
| stackPtr | input | 64 | Stack pointer value |
| indexVec | input | 256 | Index vector, element e in bits [64e+63:64e] |
| predMask | input | 4 | Predicate, bit e governs element e |
| idx32Mode | input | 1 | 1: 32-bit indices, 0: 64-bit indices |
| signExt | input | 1 | In 32-bit mode, 1 sign-extends and 0 zero-extends |
| scaleEn | input | 1 | Shift the extended index left by 3 |
| ffrIn | input | 4 | Incoming first-fault register |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqAddr | output | 64 | Request address |
| memReqNonFault | output | 1 | 1: non-faulting access, 0: normal access |
| memRspValid | input | 1 | Response beat |
| memRspData | input | 64 | Response data |
| memRspFault | input | 1 | Response fault flag |
| resultVec | output | 256 | Committed result vector |
| ffrOut | output | 4 | Committed first-fault register |
| abortOut | output | 1 | Architectural fault, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch the port protocol on every cycle. They check that a request holds its address and type until it is accepted, that a response arrives only for an accepted request, that at most one normal access is issued per operation, and that no request follows a fault. They also check that abort appears only with done, that done lasts a single cycle, and that the outputs move only right after done. Address arithmetic under each extend and scale mode, the zeroing of inactive and post-fault elements, the first-fault bit pattern and the stack-pointer alignment abort can only be shown by the bench's sweeps. These sweep every predicate, every mode and every fault position against an arithmetic reference.

// File: rtl/ffGatherPkg.sv
package ffGatherPkg;

  localparam logic [4:0] SP_REG_NUM  = 5'd31;
  localparam int         ALIGN_BITS  = 4;
  localparam int         SCALE_SHIFT = 3;

  typedef struct packed {
    logic load;     // capture operands, reset the walk
    logic skip;     // retire current element without access
    logic capture;  // retire current element with the response beat
    logic commit;   // publish working vectors to the outputs
  } ctrlStrobe_t;

  typedef struct packed {
    logic curActive;
    logic isLast;
    logic isFirst;
    logic faulted;
    logic baseMisaligned;
  } dpStatus_t;

endpackage

// File: rtl/ffGatherDatapath.sv
module ffGatherDatapath
  import ffGatherPkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 64,
  parameter int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobe_t                  strobe,
  output dpStatus_t                    status,
  input  logic [4:0]                   baseRegNum,
  input  logic [ADDR_W-1:0]            gprBase,
  input  logic [ADDR_W-1:0]            stackPtr,
  input  logic [NUM_ELEM*DATA_W-1:0]   indexVec,
  input  logic [NUM_ELEM-1:0]          predMask,
  input  logic                         idx32Mode,
  input  logic                         signExt,
  input  logic                         scaleEn,
  input  logic [NUM_ELEM-1:0]          ffrIn,
  input  logic [DATA_W-1:0]            rspData,
  input  logic                         rspFault,
  output logic [ADDR_W-1:0]            reqAddr,
  output logic                         reqNonFault,
  output logic [NUM_ELEM*DATA_W-1:0]   resultVec,
  output logic [NUM_ELEM-1:0]          ffrOut
);

  logic [ADDR_W-1:0]          baseR;
  logic [NUM_ELEM*DATA_W-1:0] idxR;
  logic [NUM_ELEM-1:0]        predR;
  logic [NUM_ELEM-1:0]        ffrInR;
  logic                       idx32R, signExtR, scaleR;
  logic [IDX_W-1:0]           elemIdx;
  logic                       firstPending;
  logic                       faultedR;
  logic [NUM_ELEM*DATA_W-1:0] workRes;
  logic [NUM_ELEM-1:0]        workFfr;

  logic                       useSp;
  logic [ADDR_W-1:0]          baseSel;

  assign useSp   = (baseRegNum == SP_REG_NUM);
  assign baseSel = useSp ? stackPtr : gprBase;

  // per-element index slices
  logic [DATA_W-1:0] idxElem [NUM_ELEM];
  genvar g;
  generate
    for (g = 0; g < NUM_ELEM; g++) begin : gSlice
      assign idxElem[g] = idxR[g*DATA_W +: DATA_W];
    end
  endgenerate

  logic [DATA_W-1:0] idxCur;
  logic [ADDR_W-1:0] idxExt;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    idxCur = idxElem[elemIdx];
    if (idx32R)
      idxExt = {{(ADDR_W-32){signExtR & idxCur[31]}}, idxCur[31:0]};
    else
      idxExt = ADDR_W'(idxCur);
    offset = scaleR ? (idxExt << SCALE_SHIFT) : idxExt;
  end

  assign reqAddr     = baseR + offset;
  assign reqNonFault = ~firstPending;

  assign status.curActive      = predR[elemIdx];
  assign status.isLast         = (elemIdx == IDX_W'(NUM_ELEM - 1));
  assign status.isFirst        = firstPending;
  assign status.faulted        = faultedR;
  assign status.baseMisaligned = useSp & (|stackPtr[ALIGN_BITS-1:0]);

  logic newFaulted;
  assign newFaulted = faultedR | rspFault;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseR        <= '0;
      idxR         <= '0;
      predR        <= '0;
      ffrInR       <= '0;
      idx32R       <= 1'b0;
      signExtR     <= 1'b0;
      scaleR       <= 1'b0;
      elemIdx      <= '0;
      firstPending <= 1'b0;
      faultedR     <= 1'b0;
      workRes      <= '0;
      workFfr      <= '0;
      resultVec    <= '0;
      ffrOut       <= '0;
    end else begin
      if (strobe.load) begin
        baseR        <= baseSel;
        idxR         <= indexVec;
        predR        <= predMask;
        ffrInR       <= ffrIn;
        idx32R       <= idx32Mode;
        signExtR     <= signExt;
        scaleR       <= scaleEn;
        elemIdx      <= '0;
        firstPending <= 1'b1;
        faultedR     <= 1'b0;
        workRes      <= '0;
        workFfr      <= '0;
      end
      if (strobe.skip) begin
        workRes[elemIdx*DATA_W +: DATA_W] <= '0;
        workFfr[elemIdx] <= ffrInR[elemIdx] & ~faultedR;
        elemIdx <= elemIdx + 1'b1;
      end
      if (strobe.capture) begin
        workRes[elemIdx*DATA_W +: DATA_W] <= rspFault ? '0 : rspData;
        workFfr[elemIdx] <= ffrInR[elemIdx] & ~newFaulted;
        faultedR     <= newFaulted;
        firstPending <= 1'b0;
        elemIdx      <= elemIdx + 1'b1;
      end
      if (strobe.commit) begin
        resultVec <= workRes;
        ffrOut    <= workFfr;
      end
    end
  end

endmodule

// File: rtl/ffGatherCtrl.sv
module ffGatherCtrl
  import ffGatherPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        memRspFault,
  output ctrlStrobe_t strobe,
  output logic        memReqValid,
  output logic        done,
  output logic        abortOut
);

  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_REQ, S_RSP, S_DONE
  } state_t;

  state_t state, nextState;
  logic   abortR, abortNext;

  always_comb begin
    strobe    = '0;
    nextState = state;
    abortNext = abortR;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          abortNext   = status.baseMisaligned;
          nextState   = status.baseMisaligned ? S_DONE : S_EVAL;
        end
      end
      S_EVAL: begin
        if (status.curActive && !status.faulted) begin
          nextState = S_REQ;
        end else begin
          strobe.skip = 1'b1;
          nextState   = status.isLast ? S_DONE : S_EVAL;
        end
      end
      S_REQ: begin
        if (memReqReady) nextState = S_RSP;
      end
      S_RSP: begin
        if (memRspValid) begin
          if (status.isFirst && memRspFault) begin
            abortNext = 1'b1;
            nextState = S_DONE;
          end else begin
            strobe.capture = 1'b1;
            nextState      = status.isLast ? S_DONE : S_EVAL;
          end
        end
      end
      S_DONE: begin
        strobe.commit = ~abortR;
        nextState     = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign memReqValid = (state == S_REQ);
  assign done        = (state == S_DONE);
  assign abortOut    = done & abortR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      abortR <= 1'b0;
    end else begin
      state  <= nextState;
      abortR <= abortNext;
    end
  end

endmodule

// File: rtl/ffGatherSeq.sv
module ffGatherSeq
  import ffGatherPkg::*;
#(
  parameter int VEC_LEN = 256,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 64,
  localparam int NUM_ELEM = VEC_LEN / DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic [4:0]                 baseRegNum,
  input  logic [ADDR_W-1:0]          gprBase,
  input  logic [ADDR_W-1:0]          stackPtr,
  input  logic [VEC_LEN-1:0]         indexVec,
  input  logic [NUM_ELEM-1:0]        predMask,
  input  logic                       idx32Mode,
  input  logic                       signExt,
  input  logic                       scaleEn,
  input  logic [NUM_ELEM-1:0]        ffrIn,
  output logic                       memReqValid,
  input  logic                       memReqReady,
  output logic [ADDR_W-1:0]          memReqAddr,
  output logic                       memReqNonFault,
  input  logic                       memRspValid,
  input  logic [DATA_W-1:0]          memRspData,
  input  logic                       memRspFault,
  output logic [VEC_LEN-1:0]         resultVec,
  output logic [NUM_ELEM-1:0]        ffrOut,
  output logic                       abortOut,
  output logic                       done
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  ffGatherCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .status      (status),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .memRspFault (memRspFault),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .done        (done),
    .abortOut    (abortOut)
  );

  ffGatherDatapath #(
    .NUM_ELEM (NUM_ELEM),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .status      (status),
    .baseRegNum  (baseRegNum),
    .gprBase     (gprBase),
    .stackPtr    (stackPtr),
    .indexVec    (indexVec),
    .predMask    (predMask),
    .idx32Mode   (idx32Mode),
    .signExt     (signExt),
    .scaleEn     (scaleEn),
    .ffrIn       (ffrIn),
    .rspData     (memRspData),
    .rspFault    (memRspFault),
    .reqAddr     (memReqAddr),
    .reqNonFault (memReqNonFault),
    .resultVec   (resultVec),
    .ffrOut      (ffrOut)
  );

endmodule

// File: rtl/ffGatherSeqChk.sv
module ffGatherSeqChk #(
  parameter int VEC_LEN  = 256,
  parameter int ADDR_W   = 64,
  parameter int NUM_ELEM = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                memReqValid,
  input logic                memReqReady,
  input logic [ADDR_W-1:0]   memReqAddr,
  input logic                memReqNonFault,
  input logic                memRspValid,
  input logic                memRspFault,
  input logic [VEC_LEN-1:0]  resultVec,
  input logic [NUM_ELEM-1:0] ffrOut,
  input logic                abortOut,
  input logic                done
);

  logic pendingR;
  logic sawFault;
  logic normalSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingR   <= 1'b0;
      sawFault   <= 1'b0;
      normalSeen <= 1'b0;
    end else begin
      if (memReqValid && memReqReady) pendingR <= 1'b1;
      else if (memRspValid)           pendingR <= 1'b0;
      if (done)                              sawFault <= 1'b0;
      else if (memRspValid && memRspFault)   sawFault <= 1'b1;
      if (done) normalSeen <= 1'b0;
      else if (memReqValid && memReqReady && !memReqNonFault) normalSeen <= 1'b1;
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqNonFault));

  // R10
  rsp_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> pendingR);

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendingR |-> !memReqValid);

  // R5
  one_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady && !memReqNonFault |-> !normalSeen);

  // R7
  no_req_after_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    sawFault |-> !memReqValid);

  // R6
  abort_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  out_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ffrOut) || !$stable(resultVec)) |-> $past(done));

endmodule

bind ffGatherSeq ffGatherSeqChk #(
  .VEC_LEN  (VEC_LEN),
  .ADDR_W   (ADDR_W),
  .NUM_ELEM (NUM_ELEM)
) uChk (
  .clk            (clk),
  .rstN           (rstN),
  .memReqValid    (memReqValid),
  .memReqReady    (memReqReady),
  .memReqAddr     (memReqAddr),
  .memReqNonFault (memReqNonFault),
  .memRspValid    (memRspValid),
  .memRspFault    (memRspFault),
  .resultVec      (resultVec),
  .ffrOut         (ffrOut),
  .abortOut       (abortOut),
  .done           (done)
);

// File: tb/ffGatherSeq_test.sv
`timescale 1ns/1ps
module ffGatherSeq_test;

  localparam int VL = 256;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    baseRegNum = '0;
  logic [63:0]   gprBase = '0;
  logic [63:0]   stackPtr = '0;
  logic [VL-1:0] indexVec = '0;
  logic [NE-1:0] predMask = '0;
  logic          idx32Mode = 1'b0;
  logic          signExt = 1'b0;
  logic          scaleEn = 1'b0;
  logic [NE-1:0] ffrIn = '0;
  logic          memReqValid;
  logic          memReqReady = 1'b0;
  logic [63:0]   memReqAddr;
  logic          memReqNonFault;
  logic          memRspValid = 1'b0;
  logic [63:0]   memRspData = '0;
  logic          memRspFault = 1'b0;
  logic [VL-1:0] resultVec;
  logic [NE-1:0] ffrOut;
  logic          abortOut;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ffGatherSeq uut (
    .clk(clk), .rstN(rstN), .start(start), .baseRegNum(baseRegNum),
    .gprBase(gprBase), .stackPtr(stackPtr), .indexVec(indexVec),
    .predMask(predMask), .idx32Mode(idx32Mode), .signExt(signExt),
    .scaleEn(scaleEn), .ffrIn(ffrIn), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memReqNonFault(memReqNonFault), .memRspValid(memRspValid),
    .memRspData(memRspData), .memRspFault(memRspFault),
    .resultVec(resultVec), .ffrOut(ffrOut), .abortOut(abortOut), .done(done)
  );

  // memory model
  logic        faultEn = 1'b0;
  logic [63:0] faultAddr = '0;
  logic [7:0]  lfsr = 8'h5B;
  int          reqTotal = 0;
  logic [63:0] logAddr [64];
  logic        logNf [64];

  function automatic logic [63:0] dataOf(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'hC3C3_5A5A_0F0F_9696;
  endfunction

  always @(posedge clk) begin
    lfsr        <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memReqReady <= lfsr[0] | lfsr[2];
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= dataOf(memReqAddr);
      memRspFault <= faultEn && (memReqAddr == faultAddr);
      logAddr[reqTotal % 64] <= memReqAddr;
      logNf[reqTotal % 64]   <= memReqNonFault;
      reqTotal <= reqTotal + 1;
    end else begin
      memRspValid <= 1'b0;
      memRspFault <= 1'b0;
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check64(input string req, input string what,
                         input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] idxOf(input int e);
    logic [31:0] lo;
    lo = (e % 2 == 1) ? (32'hFFFF_FFF0 - 32'(e * 16)) : (32'h0000_0040 + 32'(e * 24));
    return {32'h0000_0100 + 32'(e), lo};
  endfunction

  function automatic logic [63:0] addrOf(input logic [63:0] base, input logic [63:0] idx,
                                         input logic m32, input logic sx, input logic sc);
    logic [63:0] x;
    x = m32 ? (sx ? {{32{idx[31]}}, idx[31:0]} : {32'b0, idx[31:0]}) : idx;
    return base + (sc ? (x << 3) : x);
  endfunction

  logic [VL-1:0] lastRes = '0;
  logic [NE-1:0] lastFfr = '0;

  task automatic runOp(input logic [4:0] bNum, input logic [63:0] gpr, input logic [63:0] sp,
                       input logic [NE-1:0] pred, input logic [2:0] mode,
                       input logic [NE-1:0] ffrI, input int faultElem, input string tag);
    logic [63:0] base, a;
    logic [VL-1:0] expRes;
    logic [NE-1:0] expFfr;
    logic expAbort, mis, first, faulted, f;
    logic [63:0] expAddr [NE];
    logic expNf [NE];
    int n, startCnt, waitCnt;
    base = (bNum == 5'd31) ? sp : gpr;
    mis  = (bNum == 5'd31) && (sp[3:0] != 4'h0);
    for (int e = 0; e < NE; e++) indexVec[e*64 +: 64] = idxOf(e);
    faultEn   = (faultElem >= 0);
    faultAddr = (faultElem >= 0) ? addrOf(base, idxOf(faultElem), mode[2], mode[1], mode[0]) : '0;
    // reference
    expRes = '0; expFfr = '0; expAbort = mis; n = 0; first = 1'b1; faulted = 1'b0;
    if (!mis) begin
      for (int e = 0; e < NE; e++) begin
        if (!expAbort) begin
          if (pred[e] && !faulted) begin
            a = addrOf(base, idxOf(e), mode[2], mode[1], mode[0]);
            expAddr[n] = a; expNf[n] = !first; n++;
            f = faultEn && (a == faultAddr);
            if (first && f) expAbort = 1'b1;
            else begin
              first = 1'b0;
              if (f) faulted = 1'b1;
              expRes[e*64 +: 64] = f ? 64'd0 : dataOf(a);
            end
          end
          expFfr[e] = ffrI[e] & ~faulted;
        end
      end
    end
    if (expAbort) begin expRes = lastRes; expFfr = lastFfr; end
    // drive
    @(negedge clk);
    startCnt = reqTotal;
    baseRegNum = bNum; gprBase = gpr; stackPtr = sp; predMask = pred;
    idx32Mode = mode[2]; signExt = mode[1]; scaleEn = mode[0]; ffrIn = ffrI;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitCnt = 0;
    while (!done && waitCnt < 200) begin @(negedge clk); waitCnt++; end
    check64("R11", {tag, " done seen"}, VL'(done), VL'(1'b1));
    check64(mis ? "R9" : "R6", {tag, " abortOut"}, VL'(abortOut), VL'(expAbort));
    @(negedge clk);
    check64("R11", {tag, " done one cycle"}, VL'(done), VL'(1'b0));
    check64(expAbort ? "R6" : "R8", {tag, " resultVec"}, resultVec, expRes);
    check64(expAbort ? "R6" : "R7", {tag, " ffrOut"}, VL'(ffrOut), VL'(expFfr));
    check64("R4", {tag, " request count"}, VL'(reqTotal - startCnt), VL'(n));
    for (int k = 0; k < n && k < reqTotal - startCnt; k++) begin
      check64(mode[2] ? "R2" : (mode[0] ? "R1" : "R3"), {tag, " request address"},
              VL'(logAddr[(startCnt + k) % 64]), VL'(expAddr[k]));
      check64("R5", {tag, " request type"}, VL'(logNf[(startCnt + k) % 64]), VL'(expNf[k]));
    end
    lastRes = resultVec;
    lastFfr = ffrOut;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check64("R12", "done in reset", VL'(done), '0);
    check64("R12", "memReqValid in reset", VL'(memReqValid), '0);
    rstN = 1'b1;
    @(negedge clk);
    check64("R12", "resultVec after reset", resultVec, '0);
    check64("R12", "ffrOut after reset", VL'(ffrOut), '0);
    check64("R12", "abortOut after reset", VL'(abortOut), '0);

    // sweep: every predicate, every mode, no fault and a fault at each element
    for (int p = 0; p < 16; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int fe = -1; fe < NE; fe++) begin
          runOp(5'd3, 64'h0000_1000_0000_2000, 64'h0, 4'(p), 3'(m),
                ~4'(p * 3 + m), fe, "sweep");
        end
      end
    end

    // R9 stack pointer base, aligned
    runOp(5'd31, 64'hDEAD_0000_0000_0000, 64'h0000_7FFF_FFFF_F000, 4'b1111, 3'b101,
          4'b1111, -1, "R9 aligned sp");
    // R9 stack pointer misaligned: abort with no request, outputs kept
    runOp(5'd31, 64'h0000_0000_0000_4000, 64'h0000_7FFF_FFFF_F008, 4'b1111, 3'b000,
          4'b1111, -1, "R9 misaligned sp");
    // R9 non-31 register ignores stack pointer alignment
    runOp(5'd30, 64'h0000_0000_0000_4000, 64'h0000_7FFF_FFFF_F008, 4'b0110, 3'b110,
          4'b1010, 2, "R9 gpr base");
    // R6 first-element fault after a successful op leaves outputs unchanged
    runOp(5'd1, 64'h0000_0000_0001_0000, 64'h0, 4'b1011, 3'b111, 4'b1111, 0, "R6 abort");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule